// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Status Flags

This unit forms the datapath core of a small accumulator machine. It takes the accumulator byte, a second operand byte, the current flag byte and an operation code, and in the same cycle returns a result byte, a strobe that says whether that result should be written back, and a fresh flag byte. It has no storage of its own. The surrounding sequencer registers whatever it keeps.

Eight two-operand operations are chosen by `op_i`. A separate `step_i` input turns the unit into a plus-one or minus-one path on the accumulator. When `step_i` is nonzero it takes priority over `op_i`. Compare produces the flags of a subtraction but keeps the write strobe low. The incoming flag byte matters only through its carry bit, and only add-with-carry, subtract-with-borrow, increment and decrement use it.

Top module: `alu8_core`

## Requirements
- R1: The flag byte `flags_o` carries sign in bit 7, zero in bit 6, half-carry in bit 4, subtract in bit 1 and carry in bit 0. Bits 5, 3 and 2 are always 0. Of the `flags_i` byte only bit 0 has any effect on the outputs.
- R2: With `op_i`=0 (add) the result is the low byte of acc+operand and carry is bit 8 of that 9-bit sum. With `op_i`=1 (add-with-carry) the incoming carry `flags_i[0]` is added as well. Both clear the subtract flag.
- R3: With `op_i`=2 (subtract) the result is acc−operand. With `op_i`=3 (subtract-with-borrow) the incoming carry is also subtracted. Both set the subtract flag, and carry is set exactly when the 9-bit difference borrows.
- R4: For add, add-with-carry, subtract, subtract-with-borrow and compare, half-carry equals bit 4 of (acc XOR operand XOR 8-bit result).
- R5: For every operation except compare, zero is set exactly when the result byte is 0, and sign equals result bit 7.
- R6: With `op_i`=7 (compare) the flags are those that subtract would produce for the same inputs. `wr_en_o` is 0 and `res_o` equals `acc_i`.
- R7: With `op_i`=4 (AND) the result is the bitwise AND. Half-carry is set, and carry and subtract are cleared.
- R8: With `op_i`=5 (XOR) and `op_i`=6 (OR) the result is the bitwise XOR or OR. Half-carry, carry and subtract are all cleared.
- R9: Increment (`step_i`=01) returns acc+1 modulo 256. It copies `flags_i[0]` into carry and clears subtract. Half-carry is set when the low nibble of the result is 0.
- R10: Decrement (`step_i`=10 or 11) returns acc−1 modulo 256. It copies `flags_i[0]` into carry and sets subtract. Half-carry is set when the low nibble of the result is 0xF.
- R11: Any nonzero `step_i` overrides `op_i`. `wr_en_o` is 1 for every operation except compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator byte (first operand) |
| opnd_i | input | 8 | Second operand byte |
| flags_i | input | 8 | Current flag byte; only bit 0 (carry) is used |
| op_i | input | 3 | Operation code: 0 add, 1 adc, 2 sub, 3 sbc, 4 and, 5 xor, 6 or, 7 compare |
| step_i | input | 2 | 00 use `op_i`, 01 increment, 10 or 11 decrement |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result write strobe, low for compare |
| flags_o | output | 8 | New flag byte |

## Verification
The bench goes after the carry and borrow edges first: 0xFF+1, 0x00−1, and subtract-with-borrow on equal operands. A unit that took carry from the wrong bit, or dropped the folded-in carry, would return a wrong carry flag or a result off by one. The nibble edges 0x0F+1, 0x10−1, and increment and decrement across 0x0F/0x10 separate the XOR-derived half-carry of the arithmetic path from the nibble test of the step path. A mixed-up rule there shows up as a wrong bit 4. Further cases show the distinct outcomes of other wrong designs: a compare that wrote its result, a step that cleared the carry instead of keeping it, logic operations that left a stale half-carry, and unused incoming flag bits leaking into the padding bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W   = 8;
    localparam int FLAG_W   = 8;
    localparam int FLG_SIGN = 7;
    localparam int FLG_ZERO = 6;
    localparam int FLG_HALF = 4;
    localparam int FLG_SUBT = 1;
    localparam int FLG_CARY = 0;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic [FLAG_W-1:0] flg;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         half_o
);
    localparam int HB = W / 2;

    logic [W:0] wide_d;

    always_comb begin
        if (sub_i) begin
            wide_d = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        end else begin
            wide_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        end
    end

    logic [W-1:0] mix_d;
    assign sum_o  = wide_d[W-1:0];
    assign cout_o = wide_d[W];
    assign mix_d  = a_i ^ b_i ^ wide_d[W-1:0];
    assign half_o = mix_d[HB];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            2'd0:    y_o = a_i & b_i;
            2'd1:    y_o = a_i ^ b_i;
            default: y_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         dec_i,
    output logic [W-1:0] y_o,
    output logic         half_o
);
    localparam int HB = W / 2;

    always_comb begin
        if (dec_i) begin
            y_o    = a_i - {{(W-1){1'b0}}, 1'b1};
            half_o = (y_o[HB-1:0] == {HB{1'b1}});
        end else begin
            y_o    = a_i + {{(W-1){1'b0}}, 1'b1};
            half_o = (y_o[HB-1:0] == {HB{1'b0}});
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        step_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic unused_flag_bits;
    assign unused_flag_bits = ^flags_i[FLAG_W-1:1];

    alu_op_e op_d;
    assign op_d = alu_op_e'(op_i);

    logic is_sub_d, use_cin_d, cin_d;
    assign is_sub_d  = (op_d == OP_SUB) || (op_d == OP_SBC) || (op_d == OP_CMP);
    assign use_cin_d = (op_d == OP_ADC) || (op_d == OP_SBC);
    assign cin_d     = use_cin_d & flags_i[FLG_CARY];

    logic [DATA_W-1:0] arith_d, logic_d, step_d;
    logic              arith_c_d, arith_h_d, step_h_d;

    alu8_addsub #(.W(DATA_W)) i_addsub (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .cin_i  (cin_d),
        .sub_i  (is_sub_d),
        .sum_o  (arith_d),
        .cout_o (arith_c_d),
        .half_o (arith_h_d)
    );

    alu8_logic #(.W(DATA_W)) i_logic (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sel_i (op_i[1:0]),
        .y_o   (logic_d)
    );

    alu8_step #(.W(DATA_W)) i_step (
        .a_i    (acc_i),
        .dec_i  (step_i[1]),
        .y_o    (step_d),
        .half_o (step_h_d)
    );

    alu_out_t out_d;
    logic     h_d, n_d, c_d;
    logic [DATA_W-1:0] r_d;

    always_comb begin
        r_d = arith_d;
        h_d = arith_h_d;
        n_d = is_sub_d;
        c_d = arith_c_d;
        out_d.we = 1'b1;
        if (step_i != 2'b00) begin
            r_d = step_d;
            h_d = step_h_d;
            n_d = step_i[1];
            c_d = flags_i[FLG_CARY];
        end else begin
            unique case (op_d)
                OP_AND: begin
                    r_d = logic_d; h_d = 1'b1; n_d = 1'b0; c_d = 1'b0;
                end
                OP_XOR, OP_OR: begin
                    r_d = logic_d; h_d = 1'b0; n_d = 1'b0; c_d = 1'b0;
                end
                OP_CMP: out_d.we = 1'b0;
                default: ;
            endcase
        end
        out_d.flg           = '0;
        out_d.flg[FLG_SIGN] = r_d[DATA_W-1];
        out_d.flg[FLG_ZERO] = (r_d == '0);
        out_d.flg[FLG_HALF] = h_d;
        out_d.flg[FLG_SUBT] = n_d;
        out_d.flg[FLG_CARY] = c_d;
        out_d.res = out_d.we ? r_d : acc_i;
    end

    assign res_o   = out_d.res;
    assign wr_en_o = out_d.we;
    assign flags_o = out_d.flg;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [2:0]        op_i,
    input logic [1:0]        step_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic [DATA_W:0] sum9;
    assign sum9 = {1'b0, acc_i} + {1'b0, opnd_i};

    always_comb begin
        AST_FLAG_PAD: assert (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[2] == 1'b0); // R1
        if (wr_en_o) begin
            AST_ZERO_MATCH: assert (flags_o[FLG_ZERO] == (res_o == '0)); // R5
            AST_SIGN_MATCH: assert (flags_o[FLG_SIGN] == res_o[DATA_W-1]); // R5
        end
        if (step_i == 2'b00 && op_i == 3'd0) begin
            AST_ADD_SUM: assert ({flags_o[FLG_CARY], res_o} == sum9); // R2
        end
        if (step_i == 2'b00 && op_i == 3'd7) begin
            AST_CMP_HOLD: assert (!wr_en_o && res_o == acc_i); // R6
        end
        if (step_i != 2'b00) begin
            AST_STEP_CARRY: assert (flags_o[FLG_CARY] == flags_i[FLG_CARY] && wr_en_o); // R9 R10
        end
        if (step_i == 2'b00 && op_i[2] && op_i != 3'd7) begin
            AST_LOGIC_NOCARRY: assert (!flags_o[FLG_CARY] && !flags_o[FLG_SUBT]); // R7 R8
        end
    end
endmodule

bind alu8_core alu8_core_chk i_alu8_core_chk (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .op_i    (op_i),
    .step_i  (step_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .flags_o (flags_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] acc, opnd, fin;
    logic [2:0] op;
    logic [1:0] step;
    logic [7:0] res, fout;
    logic       we;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    alu8_core i_alu8_core (
        .acc_i(acc), .opnd_i(opnd), .flags_i(fin), .op_i(op), .step_i(step),
        .res_o(res), .wr_en_o(we), .flags_o(fout)
    );

    function automatic logic [16:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                            input logic [7:0] f, input logic [2:0] o,
                                            input logic [1:0] s);
        int r; int c; int h; int n; int w; int res8;
        c = 0; h = 0; n = 0; w = 1;
        if (s != 0) begin
            if (s[1]) begin r = (a + 255) % 256; n = 1; h = ((r % 16) == 15) ? 1 : 0; end
            else      begin r = (a + 1) % 256;         h = ((r % 16) == 0)  ? 1 : 0; end
            c = f[0];
            res8 = r;
        end else begin
            case (o)
                3'd0, 3'd1: begin
                    r = a + b + ((o == 3'd1) ? f[0] : 0);
                    c = (r > 255) ? 1 : 0; res8 = r % 256;
                    h = ((a ^ b ^ res8) >> 4) & 1;
                end
                3'd2, 3'd3, 3'd7: begin
                    r = a - b - ((o == 3'd3) ? f[0] : 0);
                    c = (r < 0) ? 1 : 0; res8 = (r + 512) % 256; n = 1;
                    h = ((a ^ b ^ res8) >> 4) & 1;
                    if (o == 3'd7) w = 0;
                end
                3'd4: begin res8 = a & b; h = 1; end
                3'd5: res8 = a ^ b;
                default: res8 = a | b;
            endcase
        end
        ref_alu[7:0]  = {res8[7], (res8 == 0), 1'b0, h[0], 2'b00, n[0], c[0]};
        ref_alu[8]    = w[0];
        ref_alu[16:9] = (w != 0) ? res8[7:0] : a;
    endfunction

    task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f, input logic [2:0] o, input logic [1:0] s);
        logic [16:0] exp;
        @(negedge clk);
        acc = a; opnd = b; fin = f; op = o; step = s;
        #(CLK_PERIOD/4);
        exp = ref_alu(a, b, f, o, s);
        checks++;
        if ({res, we, fout} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h f=%h op=%0d step=%0d got res=%h we=%b flg=%h exp res=%h we=%b flg=%h",
                     tag, a, b, f, o, s, res, we, fout, exp[16:9], exp[8], exp[7:0]);
        end
    endtask

    task automatic expect_lit(input string tag, input logic [7:0] er, input logic ew, input logic [7:0] ef);
        checks++;
        if (res !== er || we !== ew || fout !== ef) begin
            failures++;
            $display("FAIL %s got res=%h we=%b flg=%h exp res=%h we=%b flg=%h",
                     tag, res, we, fout, er, ew, ef);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0A1B);
        acc = 0; opnd = 0; fin = 0; op = 0; step = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        expect_lit("R1 idle zero inputs", 8'h00, 1'b1, 8'h40);

        apply("R4 add nibble carry", 8'h0F, 8'h01, 8'h00, 3'd0, 2'd0); expect_lit("R4", 8'h10, 1, 8'h10);
        apply("R2 add wrap", 8'hFF, 8'h01, 8'h00, 3'd0, 2'd0); expect_lit("R2 R5", 8'h00, 1, 8'h51);
        apply("R2 adc carry in", 8'h7F, 8'h00, 8'h01, 3'd1, 2'd0); expect_lit("R2", 8'h80, 1, 8'h90);
        apply("R3 sub half", 8'h10, 8'h01, 8'h00, 3'd2, 2'd0); expect_lit("R3", 8'h0F, 1, 8'h12);
        apply("R3 sub borrow", 8'h00, 8'h01, 8'h00, 3'd2, 2'd0); expect_lit("R3", 8'hFF, 1, 8'h93);
        apply("R3 sbc equal", 8'h05, 8'h05, 8'h01, 3'd3, 2'd0); expect_lit("R3", 8'hFF, 1, 8'h93);
        apply("R6 compare equal", 8'h42, 8'h42, 8'h00, 3'd7, 2'd0); expect_lit("R6", 8'h42, 0, 8'h42);
        apply("R6 compare borrow", 8'h01, 8'h02, 8'h00, 3'd7, 2'd0); expect_lit("R6", 8'h01, 0, 8'h93);
        apply("R7 and zero", 8'hF0, 8'h0F, 8'hFF, 3'd4, 2'd0); expect_lit("R7", 8'h00, 1, 8'h50);
        apply("R8 or sign", 8'h80, 8'h01, 8'hFF, 3'd6, 2'd0); expect_lit("R8", 8'h81, 1, 8'h80);
        apply("R8 xor zero", 8'hAA, 8'hAA, 8'hFF, 3'd5, 2'd0); expect_lit("R8", 8'h00, 1, 8'h40);
        apply("R9 inc nibble", 8'h0F, 8'h00, 8'h01, 3'd7, 2'd1); expect_lit("R9 R11", 8'h10, 1, 8'h11);
        apply("R9 inc wrap", 8'hFF, 8'h00, 8'h00, 3'd2, 2'd1); expect_lit("R9", 8'h00, 1, 8'h50);
        apply("R10 dec nibble", 8'h10, 8'h00, 8'h01, 3'd0, 2'd2); expect_lit("R10", 8'h0F, 1, 8'h13);
        apply("R10 dec zero", 8'h01, 8'h00, 8'h00, 3'd4, 2'd2); expect_lit("R10", 8'h00, 1, 8'h42);
        apply("R11 step 11 is dec", 8'h80, 8'h00, 8'h00, 3'd7, 2'd3); expect_lit("R11", 8'h7F, 1, 8'h12);
        apply("R1 unused flag bits", 8'h01, 8'h01, 8'hFE, 3'd0, 2'd0); expect_lit("R1", 8'h02, 1, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ra, rb, rf;
            logic [2:0] ro;
            logic [1:0] rs;
            ra = 8'($urandom); rb = 8'($urandom); rf = 8'($urandom);
            ro = 3'($urandom); rs = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
            if (i % 16 == 0) ra = 8'hFF;
            if (i % 16 == 1) rb = 8'h00;
            apply("R2 R3 R4 R5 R7 R8 R9 R10 random", ra, rb, rf, ro, rs);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule